// File: doc/BRIEF.md
# Quad Wiper Register Controller

This block carries out decoded instructions for four digitally controlled potentiometer channels. Each channel has one volatile 8-bit wiper register that sets the tap position, plus four 8-bit data registers that stand in for nonvolatile storage. A serial front end outside the block delivers bytes to it:

- an instruction byte, strobed by `cmd_valid`;
- an optional data byte, strobed by `data_valid`;
- a `stop_strobe` when the host ends the transaction.

The controller handles these operations:

- host reads and writes of the wiper and data registers;
- single-channel and all-channel transfers between the wiper and a data register;
- a write-protect pin that blocks nonvolatile writes;
- a busy window that models the nonvolatile write cycle.

For each channel the wiper register is decoded into a one-hot select of 256 tap lines. That select drives the switches of an analog resistor array, which lies outside this block.

There are two resets. `nv_rst_n` loads the data registers with their factory contents: 16·(pot+1)+reg. `rst_n` models power-up. While `rst_n` is low, the wiper registers read 0. On the first clock edge after `rst_n` is released, each channel copies its data register 0 into its wiper register.

Top module: `dcp_quad_ctrl`

## Requirements
- R1: On the first clock edge after `rst_n` is released, every wiper register is loaded from that channel's data register 0. This holds for the values left in data register 0 by earlier writes, and also for the factory values 16·(pot+1)+reg set by `nv_rst_n`. `busy` stays high until that load is done.
- R2: The instruction byte is split into fields: opcode in bits [7:4], register index in bits [3:2], potentiometer index in bits [1:0]. Opcode 1 (read wiper) and opcode 3 (read data register) return the selected value on `rd_data`, with `rd_valid` high for one cycle, in the cycle after the instruction is accepted.
- R3: Opcode 2 (write wiper) loads the data byte into the selected wiper when the data byte arrives. It needs no stop.
- R4: Opcode 4 (write data register) commits its data byte only when `stop_strobe` follows the data byte. A command that is aborted by a new instruction, or by a stop sent before the data byte, changes no register.
- R5: Opcode 5 copies the selected data register of the selected pot into its wiper on the instruction byte.
- R6: Opcode 6 copies the selected pot's wiper into its selected data register when `stop_strobe` arrives. Data registers change only on such a commit.
- R7: Opcode 7 (all-channel load) and opcode 8 (all-channel store) act on all four pots with the register index. The pot field is ignored.
- R8: While `wp_n` is low at the stop, no data register changes and `busy` does not rise.
- R9: A committed nonvolatile write holds `busy` high for exactly `WR_CYCLES` cycles. Instructions that arrive while `busy` is high are neither acknowledged nor executed.
- R10: An opcode outside 1..8 is acknowledged but changes no register.
- R11: For each pot, tap select slice [p·256 +: 256] is one-hot, with the single bit at the wiper value. This holds at codes 0 and 255.
- R12: Every instruction accepted while not busy gives a one-cycle `cmd_ack` pulse in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset; triggers the recall of data register 0 |
| nv_rst_n | input | 1 | Asynchronous active-low factory initialisation of the data registers |
| cmd_valid | input | 1 | Instruction byte strobe |
| cmd_byte | input | 8 | Instruction byte (opcode, register index, pot index) |
| data_valid | input | 1 | Data byte strobe |
| data_byte | input | 8 | Host data byte |
| stop_strobe | input | 1 | End-of-transaction strobe |
| wp_n | input | 1 | Write protect; low blocks nonvolatile writes |
| cmd_ack | output | 1 | Instruction accepted, one cycle after the strobe |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read data |
| busy | output | 1 | Recall or nonvolatile write in progress |
| tap_sel | output | 1024 | Four one-hot 256-line tap selects, pot 0 in the low bits |

## Verification
The hardest situation to reach is a command that arrives in the middle of the busy window, after a committed write. The stimulus first completes a write-data-register transaction with write protect high. It then sends a further instruction while `busy` is still high, checks that no acknowledge comes back, and counts the busy cycles to confirm the window length. The case where data register 0 survives a power-up reset is reached by an all-channel store followed by a pulse of `rst_n` alone. The recall must then bring back the stored values rather than the factory ones.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  localparam int unsigned DCP_NPOT = 4;
  localparam int unsigned DCP_NREG = 4;
  localparam int unsigned DCP_WW   = 8;
  localparam int unsigned DCP_TAPS = 1 << DCP_WW;

  typedef enum logic [1:0] {SQ_IDLE, SQ_DATA, SQ_STOP} seq_state_e;

  function automatic logic [DCP_NPOT-1:0] pot_mask(input logic [1:0] idx, input logic all);
    pot_mask = all ? '1 : (DCP_NPOT'(1) << idx);
  endfunction

  function automatic logic [DCP_WW-1:0] factory_value(input int unsigned pot, input int unsigned rsel);
    factory_value = DCP_WW'(16 * (pot + 1) + rsel);
  endfunction

  function automatic logic [DCP_TAPS-1:0] tap_decode(input logic [DCP_WW-1:0] code);
    tap_decode = DCP_TAPS'(1) << code;
  endfunction
endpackage

// File: rtl/dcp_busy_timer.sv
module dcp_busy_timer #(
  parameter int unsigned CYCLES = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int unsigned CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (start_i)          cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/dcp_cmd_seq.sv
module dcp_cmd_seq
  import dcp_pkg::*;
#(
  parameter logic [3:0] OP_RD_WCR = 4'h1,
  parameter logic [3:0] OP_WR_WCR = 4'h2,
  parameter logic [3:0] OP_RD_DR  = 4'h3,
  parameter logic [3:0] OP_WR_DR  = 4'h4,
  parameter logic [3:0] OP_LOAD   = 4'h5,
  parameter logic [3:0] OP_STORE  = 4'h6,
  parameter logic [3:0] OP_GLOAD  = 4'h7,
  parameter logic [3:0] OP_GSTORE = 4'h8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hold_i,
  input  logic                cmd_valid_i,
  input  logic [7:0]          cmd_byte_i,
  input  logic                data_valid_i,
  input  logic [DCP_WW-1:0]   data_byte_i,
  input  logic                stop_i,
  input  logic                wp_n_i,
  output logic                cmd_ack_o,
  output logic                rd_req_o,
  output logic                rd_dr_o,
  output logic [1:0]          rd_pot_o,
  output logic [1:0]          rd_reg_o,
  output logic [DCP_NPOT-1:0] ld_mask_o,
  output logic [1:0]          ld_reg_o,
  output logic [DCP_NPOT-1:0] hw_mask_o,
  output logic [DCP_WW-1:0]   hw_data_o,
  output logic [DCP_NPOT-1:0] st_mask_o,
  output logic [1:0]          st_reg_o,
  output logic                st_src_wcr_o,
  output logic [DCP_WW-1:0]   st_data_o,
  output logic                commit_o
);
  seq_state_e        state_q;
  logic [3:0]        lat_op_q;
  logic [1:0]        lat_reg_q, lat_pot_q;
  logic [DCP_WW-1:0] lat_data_q;
  logic              ack_q;

  logic       accept, data_take, stop_ok;
  logic [3:0] op;
  logic [1:0] c_reg, c_pot;

  assign op      = cmd_byte_i[7:4];
  assign c_reg   = cmd_byte_i[3:2];
  assign c_pot   = cmd_byte_i[1:0];
  assign accept  = cmd_valid_i && !hold_i;
  assign data_take = (state_q == SQ_DATA) && data_valid_i && !accept;
  assign stop_ok = (state_q == SQ_STOP) && stop_i && !accept;

  always_comb begin
    rd_req_o  = accept && (op == OP_RD_WCR || op == OP_RD_DR);
    rd_dr_o   = (op == OP_RD_DR);
    rd_pot_o  = c_pot;
    rd_reg_o  = c_reg;
    ld_reg_o  = c_reg;
    ld_mask_o = '0;
    if (accept && op == OP_LOAD)  ld_mask_o = pot_mask(c_pot, 1'b0);
    if (accept && op == OP_GLOAD) ld_mask_o = pot_mask(c_pot, 1'b1);
    hw_mask_o = (data_take && lat_op_q == OP_WR_WCR) ? pot_mask(lat_pot_q, 1'b0) : '0;
    hw_data_o = data_byte_i;
    commit_o  = stop_ok && wp_n_i;
    st_mask_o = commit_o ? pot_mask(lat_pot_q, lat_op_q == OP_GSTORE) : '0;
    st_reg_o  = lat_reg_q;
    st_src_wcr_o = (lat_op_q != OP_WR_DR);
    st_data_o = lat_data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= SQ_IDLE;
      lat_op_q   <= '0;
      lat_reg_q  <= '0;
      lat_pot_q  <= '0;
      lat_data_q <= '0;
      ack_q      <= 1'b0;
    end else begin
      ack_q <= accept;
      if (accept) begin
        lat_op_q  <= op;
        lat_reg_q <= c_reg;
        lat_pot_q <= c_pot;
        if (op == OP_WR_WCR || op == OP_WR_DR)      state_q <= SQ_DATA;
        else if (op == OP_STORE || op == OP_GSTORE) state_q <= SQ_STOP;
        else                                        state_q <= SQ_IDLE;
      end else if (data_take) begin
        lat_data_q <= data_byte_i;
        state_q    <= (lat_op_q == OP_WR_DR) ? SQ_STOP : SQ_IDLE;
      end else if (stop_i) begin
        state_q <= SQ_IDLE;
      end
    end
  end

  assign cmd_ack_o = ack_q;
endmodule

// File: rtl/dcp_channel.sv
module dcp_channel
  import dcp_pkg::*;
#(
  parameter int unsigned POT_ID = 0
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       nv_rst_n,
  input  logic                       recall_i,
  input  logic                       ld_i,
  input  logic [1:0]                 ld_reg_i,
  input  logic                       hw_i,
  input  logic [DCP_WW-1:0]          hw_data_i,
  input  logic                       st_i,
  input  logic [1:0]                 st_reg_i,
  input  logic                       st_src_wcr_i,
  input  logic [DCP_WW-1:0]          st_data_i,
  output logic [DCP_WW-1:0]          wcr_o,
  output logic [DCP_NREG*DCP_WW-1:0] dr_o,
  output logic [DCP_TAPS-1:0]        tap_o
);
  logic [DCP_WW-1:0] wcr_q;
  logic [DCP_WW-1:0] dr_q [DCP_NREG];

  for (genvar r = 0; r < DCP_NREG; r++) begin : g_dr
    always_ff @(posedge clk or negedge nv_rst_n) begin
      if (!nv_rst_n)
        dr_q[r] <= factory_value(POT_ID, r);
      else if (st_i && st_reg_i == 2'(r))
        dr_q[r] <= st_src_wcr_i ? wcr_q : st_data_i;
    end
    assign dr_o[r*DCP_WW +: DCP_WW] = dr_q[r];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        wcr_q <= '0;
    else if (recall_i) wcr_q <= dr_q[0];
    else if (hw_i)     wcr_q <= hw_data_i;
    else if (ld_i)     wcr_q <= dr_q[ld_reg_i];
  end

  assign wcr_o = wcr_q;
  assign tap_o = tap_decode(wcr_q);
endmodule

// File: rtl/dcp_quad_ctrl.sv
module dcp_quad_ctrl
  import dcp_pkg::*;
#(
  parameter int unsigned WR_CYCLES = 250000,
  parameter logic [3:0] OP_RD_WCR = 4'h1,
  parameter logic [3:0] OP_WR_WCR = 4'h2,
  parameter logic [3:0] OP_RD_DR  = 4'h3,
  parameter logic [3:0] OP_WR_DR  = 4'h4,
  parameter logic [3:0] OP_LOAD   = 4'h5,
  parameter logic [3:0] OP_STORE  = 4'h6,
  parameter logic [3:0] OP_GLOAD  = 4'h7,
  parameter logic [3:0] OP_GSTORE = 4'h8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         nv_rst_n,
  input  logic                         cmd_valid,
  input  logic [7:0]                   cmd_byte,
  input  logic                         data_valid,
  input  logic [7:0]                   data_byte,
  input  logic                         stop_strobe,
  input  logic                         wp_n,
  output logic                         cmd_ack,
  output logic                         rd_valid,
  output logic [7:0]                   rd_data,
  output logic                         busy,
  output logic [DCP_NPOT*DCP_TAPS-1:0] tap_sel
);
  localparam int unsigned DRW = DCP_NREG * DCP_WW;

  logic recall_q, wr_busy, hold, commit_w;
  logic rd_req, rd_dr;
  logic [1:0] rd_pot, rd_reg, ld_reg, st_reg;
  logic [DCP_NPOT-1:0] ld_mask, hw_mask, st_mask;
  logic [DCP_WW-1:0] hw_data, st_data;
  logic st_src_wcr;
  logic [DCP_WW-1:0] wcr_w [DCP_NPOT];
  logic [DRW-1:0]    dr_w  [DCP_NPOT];
  logic [DCP_NPOT*DCP_WW-1:0] wcr_all;
  logic [DCP_NPOT*DRW-1:0]    dr_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) recall_q <= 1'b1;
    else        recall_q <= 1'b0;
  end

  assign hold = recall_q || wr_busy;
  assign busy = hold;

  dcp_cmd_seq #(
    .OP_RD_WCR(OP_RD_WCR), .OP_WR_WCR(OP_WR_WCR), .OP_RD_DR(OP_RD_DR),
    .OP_WR_DR(OP_WR_DR), .OP_LOAD(OP_LOAD), .OP_STORE(OP_STORE),
    .OP_GLOAD(OP_GLOAD), .OP_GSTORE(OP_GSTORE)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .hold_i(hold),
    .cmd_valid_i(cmd_valid), .cmd_byte_i(cmd_byte),
    .data_valid_i(data_valid), .data_byte_i(data_byte),
    .stop_i(stop_strobe), .wp_n_i(wp_n),
    .cmd_ack_o(cmd_ack), .rd_req_o(rd_req), .rd_dr_o(rd_dr),
    .rd_pot_o(rd_pot), .rd_reg_o(rd_reg),
    .ld_mask_o(ld_mask), .ld_reg_o(ld_reg),
    .hw_mask_o(hw_mask), .hw_data_o(hw_data),
    .st_mask_o(st_mask), .st_reg_o(st_reg), .st_src_wcr_o(st_src_wcr),
    .st_data_o(st_data), .commit_o(commit_w)
  );

  dcp_busy_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(commit_w), .busy_o(wr_busy)
  );

  for (genvar p = 0; p < DCP_NPOT; p++) begin : g_pot
    dcp_channel #(.POT_ID(p)) u_ch (
      .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .recall_i(recall_q),
      .ld_i(ld_mask[p]), .ld_reg_i(ld_reg),
      .hw_i(hw_mask[p]), .hw_data_i(hw_data),
      .st_i(st_mask[p]), .st_reg_i(st_reg), .st_src_wcr_i(st_src_wcr),
      .st_data_i(st_data),
      .wcr_o(wcr_w[p]), .dr_o(dr_w[p]),
      .tap_o(tap_sel[p*DCP_TAPS +: DCP_TAPS])
    );
    assign wcr_all[p*DCP_WW +: DCP_WW] = wcr_w[p];
    assign dr_all[p*DRW +: DRW]        = dr_w[p];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req)
        rd_data <= rd_dr ? dr_w[rd_pot][int'(rd_reg)*DCP_WW +: DCP_WW] : wcr_w[rd_pot];
    end
  end
endmodule

// File: rtl/dcp_quad_ctrl_chk.sv
module dcp_quad_ctrl_chk
  import dcp_pkg::*;
(
  input logic                                 clk,
  input logic                                 rst_n,
  input logic                                 nv_rst_n,
  input logic                                 wp_n,
  input logic                                 cmd_valid,
  input logic                                 cmd_ack,
  input logic                                 busy,
  input logic                                 recall,
  input logic                                 commit,
  input logic [DCP_NPOT*DCP_WW-1:0]           wcr_all,
  input logic [DCP_NPOT*DCP_NREG*DCP_WW-1:0]  dr_all,
  input logic [DCP_NPOT*DCP_TAPS-1:0]         tap_sel
);
  localparam int unsigned DRW = DCP_NREG * DCP_WW;

  for (genvar p = 0; p < DCP_NPOT; p++) begin : g_p
    assert_recall_dr0_R1: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
      $fell(recall) |-> wcr_all[p*DCP_WW +: DCP_WW] == $past(dr_all[p*DRW +: DCP_WW]));
    assert_tap_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(tap_sel[p*DCP_TAPS +: DCP_TAPS]) == 1);
  end

  assert_wp_keeps_dr_R8: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
    !wp_n |=> $stable(dr_all));
  assert_dr_needs_commit_R6: assert property (@(posedge clk) disable iff (!rst_n || !nv_rst_n)
    !commit |=> $stable(dr_all));
  assert_commit_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> busy);
  assert_busy_from_commit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(commit));
  assert_busy_no_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cmd_valid |=> !cmd_ack);
  assert_ack_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && cmd_valid |=> cmd_ack);
endmodule

bind dcp_quad_ctrl dcp_quad_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n), .wp_n(wp_n),
  .cmd_valid(cmd_valid), .cmd_ack(cmd_ack), .busy(busy),
  .recall(recall_q), .commit(commit_w),
  .wcr_all(wcr_all), .dr_all(dr_all), .tap_sel(tap_sel)
);

// File: tb/tb_dcp_quad_ctrl.sv
`timescale 1ns/1ps
module tb_dcp_quad_ctrl;
  localparam int WRC = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0, nv_rst_n = 1'b0;
  logic cmd_valid = 1'b0, data_valid = 1'b0, stop_strobe = 1'b0, wp_n = 1'b1;
  logic [7:0] cmd_byte = '0, data_byte = '0;
  logic cmd_ack, rd_valid, busy;
  logic [7:0] rd_data;
  logic [1023:0] tap_sel;

  int n_tests = 0, n_fail = 0;
  logic last_ack, last_rv;
  logic [7:0] last_rd;
  logic [7:0] m_wcr [4];
  logic [7:0] m_dr  [4][4];

  always #2.5 clk = ~clk;

  dcp_quad_ctrl #(.WR_CYCLES(WRC)) dut (
    .clk(clk), .rst_n(rst_n), .nv_rst_n(nv_rst_n),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .data_valid(data_valid), .data_byte(data_byte),
    .stop_strobe(stop_strobe), .wp_n(wp_n),
    .cmd_ack(cmd_ack), .rd_valid(rd_valid), .rd_data(rd_data),
    .busy(busy), .tap_sel(tap_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send_cmd(input logic [3:0] op, input logic [1:0] rs, input logic [1:0] pt);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_byte = {op, rs, pt};
    @(negedge clk);
    cmd_valid = 1'b0;
    last_ack = cmd_ack; last_rv = rd_valid; last_rd = rd_data;
  endtask

  task automatic send_data(input logic [7:0] d);
    @(negedge clk); data_valid = 1'b1; data_byte = d;
    @(negedge clk); data_valid = 1'b0;
  endtask

  task automatic send_stop();
    @(negedge clk); stop_strobe = 1'b1;
    @(negedge clk); stop_strobe = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic read_wcr(input int p, input string tag);
    send_cmd(4'h1, 2'd0, 2'(p));
    chk({tag, " rd_valid"}, 32'(last_rv), 32'd1);
    chk({tag, " wiper"}, 32'(last_rd), 32'(m_wcr[p]));
  endtask

  task automatic read_dr(input int p, input int r, input string tag);
    send_cmd(4'h3, 2'(r), 2'(p));
    chk({tag, " data reg"}, 32'(last_rd), 32'(m_dr[p][r]));
  endtask

  task automatic check_tap(input int p, input string tag);
    logic [255:0] sl;
    sl = tap_sel[p*256 +: 256];
    chk({tag, " tap count"}, $countones(sl), 32'd1);
    chk({tag, " tap bit"}, 32'(sl[m_wcr[p]]), 32'd1);
  endtask

  task automatic t_reset_recall();
    for (int p = 0; p < 4; p++)
      for (int r = 0; r < 4; r++) m_dr[p][r] = 8'(16 * (p + 1) + r);
    rst_n = 1'b0; nv_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 wiper zero in reset", 32'(tap_sel[0]), 32'd1);
    rst_n = 1'b1; nv_rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after recall", 32'(busy), 32'd0);
    for (int p = 0; p < 4; p++) begin
      m_wcr[p] = m_dr[p][0];
      read_wcr(p, "R1 R2 recall");
      check_tap(p, "R11 recall");
    end
    chk("R12 ack", 32'(last_ack), 32'd1);
    read_dr(2, 3, "R2");
  endtask

  task automatic t_write_wiper();
    send_cmd(4'h2, 2'd0, 2'd1);
    send_data(8'hA5); m_wcr[1] = 8'hA5;
    check_tap(1, "R3 R11 A5");
    read_wcr(1, "R3");
    send_cmd(4'h2, 2'd0, 2'd2); send_data(8'hFF); m_wcr[2] = 8'hFF;
    check_tap(2, "R11 top code");
    send_cmd(4'h2, 2'd0, 2'd3); send_data(8'h00); m_wcr[3] = 8'h00;
    check_tap(3, "R11 bottom code");
    chk("R3 busy stays low", 32'(busy), 32'd0);
  endtask

  task automatic t_write_dr();
    int n;
    send_cmd(4'h4, 2'd2, 2'd3); send_data(8'h5A);
    read_dr(3, 2, "R4 before stop");
    chk("R4 aborted by read", 32'(busy), 32'd0);
    send_cmd(4'h4, 2'd2, 2'd3); send_data(8'h5A);
    send_stop(); m_dr[3][2] = 8'h5A;
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (n == 3) begin
        send_cmd(4'h2, 2'd0, 2'd0);
        chk("R9 no ack while busy", 32'(last_ack), 32'd0);
        n++;
        data_valid = 1'b1; data_byte = 8'h77;
        @(negedge clk); data_valid = 1'b0; n++;
      end else @(negedge clk);
    end
    chk("R9 busy length", n, WRC);
    read_wcr(0, "R9 ignored write");
    read_dr(3, 2, "R4 committed");
    send_cmd(4'h4, 2'd1, 2'd0); send_stop(); send_data(8'hEE);
    chk("R4 stop before data no busy", 32'(busy), 32'd0);
    read_dr(0, 1, "R4 stop before data");
  endtask

  task automatic t_transfers();
    send_cmd(4'h5, 2'd2, 2'd0); m_wcr[0] = m_dr[0][2];
    read_wcr(0, "R5 load");
    check_tap(0, "R5 tap");
    send_cmd(4'h6, 2'd1, 2'd1);
    read_dr(1, 1, "R6 before stop");
    send_cmd(4'h6, 2'd1, 2'd1); send_stop(); m_dr[1][1] = m_wcr[1];
    wait_idle();
    read_dr(1, 1, "R6 store");
    send_cmd(4'h7, 2'd3, 2'd2);
    for (int p = 0; p < 4; p++) begin
      m_wcr[p] = m_dr[p][3];
      read_wcr(p, "R7 global load");
    end
    for (int p = 0; p < 4; p++) begin
      send_cmd(4'h2, 2'd0, 2'(p)); send_data(8'(8'hC0 + p)); m_wcr[p] = 8'(8'hC0 + p);
    end
    send_cmd(4'h8, 2'd0, 2'd1); send_stop();
    for (int p = 0; p < 4; p++) m_dr[p][0] = m_wcr[p];
    wait_idle();
    for (int p = 0; p < 4; p++) read_dr(p, 0, "R7 global store");
  endtask

  task automatic t_protect_unknown();
    wp_n = 1'b0;
    send_cmd(4'h4, 2'd3, 2'd0); send_data(8'h99); send_stop();
    chk("R8 no busy when protected", 32'(busy), 32'd0);
    read_dr(0, 3, "R8 data write blocked");
    send_cmd(4'h8, 2'd2, 2'd0); send_stop();
    chk("R8 global store no busy", 32'(busy), 32'd0);
    read_dr(2, 2, "R8 global store blocked");
    wp_n = 1'b1;
    send_cmd(4'hF, 2'd1, 2'd1);
    chk("R10 unknown acked", 32'(last_ack), 32'd1);
    send_stop();
    chk("R10 no busy", 32'(busy), 32'd0);
    read_wcr(1, "R10 wiper unchanged");
    read_dr(1, 1, "R10 data unchanged");
  endtask

  task automatic t_power_recall();
    send_cmd(4'h2, 2'd0, 2'd2); send_data(8'h3C);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk("R1 busy during recall", 32'(busy), 32'd1);
    @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      m_wcr[p] = m_dr[p][0];
      read_wcr(p, "R1 recall kept dr0");
    end
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    t_reset_recall();
    t_write_wiper();
    t_write_dr();
    t_transfers();
    t_protect_unknown();
    t_power_recall();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule